// File: doc/BRIEF.md
# Single-Pin GPIO Controller With Interrupt Triggering

This block manages one general-purpose pin of a larger device. A two-bit mode field puts the pin in one of four states: parked at high impedance, sampled as an input, or driven as an output at a fixed low or high level (enough to switch an indicator LED). In input mode the pin becomes an interrupt source. A second two-bit field selects what counts as an interrupt: the pin being low, the pin being high, a rising transition or a falling transition.

The asynchronous pad value passes through a flop-chain synchroniser before any detection. A detected condition sets a sticky status bit. The host clears that bit by reading it through a read strobe from the surrounding register port. The status bit drives the block's contribution to the shared device interrupt line. With the default polarity that line is active low, so an edge event shows as a low-going pulse that lasts until the host reads the status.

Top module: `gpio_pin_ctl`

## Requirements
- R1: After reset, pad_oe is 0, pad_out is 0, stat_bit is 0 and irq_line is inactive (1 with the default active-low polarity).
- R2: With mode_sel = 00 (disabled), pad_oe is 0 and pad_out is 0, and no pad activity sets stat_bit.
- R3: With mode_sel = 10, pad_oe is 1 and pad_out is 0. With mode_sel = 11, pad_oe is 1 and pad_out is 1. In both output modes pad activity never sets stat_bit.
- R4: The pad passes through two synchroniser flops. A change of pad_in made between two clock edges reaches stat_bit at the third rising edge after the change, and not earlier.
- R5: With mode_sel = 01 and trig_sel = 00, stat_bit is set on every cycle in which the synchronised pad level is 0.
- R6: With mode_sel = 01 and trig_sel = 01, stat_bit is set once for each 0-to-1 transition of the synchronised pad.
- R7: With mode_sel = 01 and trig_sel = 10, stat_bit is set once for each 1-to-0 transition of the synchronised pad.
- R8: With mode_sel = 01 and trig_sel = 11, stat_bit is set on every cycle in which the synchronised pad level is 1.
- R9: A cycle with stat_rd = 1 clears stat_bit at that clock edge when no new trigger condition occurs in the same cycle.
- R10: When a trigger condition and stat_rd fall in the same cycle, the trigger wins and stat_bit stays 1.
- R11: irq_line is the inverse of stat_bit when ACTIVE_LOW = 1, and equal to it otherwise.
- R12: At any clock edge where mode_sel is not 01, stat_bit is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Pin mode: 00 off, 01 input, 10 drive low, 11 drive high |
| trig_sel | input | 2 | Trigger: 00 level low, 01 rising, 10 falling, 11 level high |
| pad_in | input | 1 | Asynchronous pad input value |
| stat_rd | input | 1 | One-cycle read strobe for the status bit |
| pad_oe | output | 1 | Output enable to the pad |
| pad_out | output | 1 | Output level to the pad |
| stat_bit | output | 1 | Sticky interrupt status bit |
| irq_line | output | 1 | Request into the device interrupt line |

## Verification
A host read of the status bit and a new trigger condition can happen in the same cycle. This is the case where a lost interrupt would otherwise hide. The bench forces this case directly by holding the pad high in level-high mode while it pulses the read strobe, and it expects the bit to survive. It then repeats the read with the pad quiet and expects the bit to clear. Random traffic keeps read strobes, pad toggles and mode or trigger changes landing together, and a cycle-level reference built from the requirements judges every cycle.

// File: rtl/gpio_pin_pkg.sv
package gpio_pin_pkg;
   typedef enum logic [1:0] {
      MODE_OFF  = 2'b00,
      MODE_IN   = 2'b01,
      MODE_DRV0 = 2'b10,
      MODE_DRV1 = 2'b11
   } pin_mode_e;

   typedef enum logic [1:0] {
      TRIG_LVL_LO = 2'b00,
      TRIG_RISE   = 2'b01,
      TRIG_FALL   = 2'b10,
      TRIG_LVL_HI = 2'b11
   } pin_trig_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   if (STAGES < 2) begin : g_bad_depth
      $error("gpio_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain[i] <= 1'b0;
         end else begin
            if (i == 0) chain[i] <= d_async;
            else        chain[i] <= chain[(i == 0) ? 0 : i-1];
         end
      end
   end

   assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/gpio_trig.sv
module gpio_trig
   import gpio_pin_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      arm,
   input  pin_trig_e trig,
   input  logic      lvl,
   output logic      ev
);
   logic prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= lvl;
   end

   logic hit;
   always_comb begin
      unique case (trig)
         TRIG_LVL_LO: hit = ~lvl;
         TRIG_RISE:   hit = lvl & ~prev;
         TRIG_FALL:   hit = ~lvl & prev;
         TRIG_LVL_HI: hit = lvl;
         default:     hit = 1'b0;
      endcase
   end

   assign ev = arm & hit;
endmodule

// File: rtl/gpio_stat.sv
module gpio_stat (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic ev,
   input  logic rd,
   output logic stat
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    stat <= 1'b0;
      else if (!arm) stat <= 1'b0;
      else if (ev)   stat <= 1'b1;
      else if (rd)   stat <= 1'b0;
   end
endmodule

// File: rtl/gpio_pin_ctl.sv
module gpio_pin_ctl
   import gpio_pin_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter bit ACTIVE_LOW  = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode_sel,
   input  logic [1:0] trig_sel,
   input  logic       pad_in,
   input  logic       stat_rd,
   output logic       pad_oe,
   output logic       pad_out,
   output logic       stat_bit,
   output logic       irq_line
);
   pin_mode_e mode;
   pin_trig_e trig;
   logic      in_mode;
   logic      sync_lvl;
   logic      trig_ev;

   assign mode    = pin_mode_e'(mode_sel);
   assign trig    = pin_trig_e'(trig_sel);
   assign in_mode = (mode == MODE_IN);

   gpio_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (pad_in),
      .q_sync  (sync_lvl)
   );

   gpio_trig u_trig (
      .clk   (clk),
      .rst_n (rst_n),
      .arm   (in_mode),
      .trig  (trig),
      .lvl   (sync_lvl),
      .ev    (trig_ev)
   );

   gpio_stat u_stat (
      .clk   (clk),
      .rst_n (rst_n),
      .arm   (in_mode),
      .ev    (trig_ev),
      .rd    (stat_rd),
      .stat  (stat_bit)
   );

   always_comb begin
      pad_oe  = 1'b0;
      pad_out = 1'b0;
      if (mode == MODE_DRV0 || mode == MODE_DRV1) begin
         pad_oe  = 1'b1;
         pad_out = (mode == MODE_DRV1);
      end
   end

   if (ACTIVE_LOW) begin : g_irq_low
      assign irq_line = ~stat_bit;
   end else begin : g_irq_high
      assign irq_line = stat_bit;
   end
endmodule

// File: rtl/gpio_pin_chk.sv
module gpio_pin_chk #(
   parameter bit ACTIVE_LOW = 1'b1
) (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] mode_sel,
   input logic       stat_rd,
   input logic       pad_oe,
   input logic       pad_out,
   input logic       stat_bit,
   input logic       irq_line,
   input logic       ev
);
   // R2: disabled pin is never driven
   p_off_hiz_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sel == 2'b00) |-> (!pad_oe && !pad_out));

   // R3: output modes drive the selected level
   p_drive_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mode_sel[1] |-> (pad_oe && (pad_out == mode_sel[0])));

   // R9: a read with no fresh trigger empties the status
   p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !ev) |=> !stat_bit);

   // R10: a trigger always leaves the status set, even under a read
   p_event_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ev |=> stat_bit);

   // R11: interrupt line follows the status with the chosen polarity
   p_irq_polarity_r11: assert property (@(posedge clk) disable iff (!rst_n)
      irq_line == (ACTIVE_LOW ? !stat_bit : stat_bit));

   // R12: outside input mode the status is cleared
   p_no_irq_outside_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sel != 2'b01) |=> !stat_bit);
endmodule

bind gpio_pin_ctl gpio_pin_chk #(.ACTIVE_LOW(ACTIVE_LOW)) u_gpio_pin_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mode_sel (mode_sel),
   .stat_rd  (stat_rd),
   .pad_oe   (pad_oe),
   .pad_out  (pad_out),
   .stat_bit (stat_bit),
   .irq_line (irq_line),
   .ev       (trig_ev)
);

// File: tb/test_gpio_pin_ctl.sv
module test_gpio_pin_ctl;
   localparam time CLK_PERIOD = 10ns;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode_sel = 2'b00;
   logic [1:0] trig_sel = 2'b00;
   logic       pad_in = 1'b0;
   logic       stat_rd = 1'b0;
   logic       pad_oe, pad_out, stat_bit, irq_line;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_pin_ctl i_gpio_pin_ctl (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .trig_sel(trig_sel),
      .pad_in(pad_in), .stat_rd(stat_rd), .pad_oe(pad_oe), .pad_out(pad_out),
      .stat_bit(stat_bit), .irq_line(irq_line)
   );

   // Reference built from the requirements: two-flop sync, previous level, sticky bit
   logic m_s1, m_s2, m_prev, m_stat;
   function automatic bit trig_hit(input logic [1:0] t, input logic cur, input logic prv);
      case (t)
         2'b00:   return !cur;
         2'b01:   return cur && !prv;
         2'b10:   return !cur && prv;
         default: return cur;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_s1 <= 1'b0; m_s2 <= 1'b0; m_prev <= 1'b0; m_stat <= 1'b0;
      end else begin
         m_s1   <= pad_in;
         m_s2   <= m_s1;
         m_prev <= m_s2;
         if (mode_sel != 2'b01)                     m_stat <= 1'b0;
         else if (trig_hit(trig_sel, m_s2, m_prev)) m_stat <= 1'b1;
         else if (stat_rd)                          m_stat <= 1'b0;
      end
   end

   task automatic check(input bit act, input bit exp, input string req);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      // R1: reset state
      check(pad_oe, 1'b0, "R1");
      check(pad_out, 1'b0, "R1");
      check(stat_bit, 1'b0, "R1");
      check(irq_line, 1'b1, "R1");
      rst_n = 1'b1;
      tick();

      // R2: disabled
      mode_sel = 2'b00; pad_in = 1'b1;
      repeat (4) tick();
      check(pad_oe, 1'b0, "R2");
      check(pad_out, 1'b0, "R2");
      check(stat_bit, 1'b0, "R2");

      // R3: output low, output high
      mode_sel = 2'b10; trig_sel = 2'b11;
      repeat (4) tick();
      check(pad_oe, 1'b1, "R3");
      check(pad_out, 1'b0, "R3");
      check(stat_bit, 1'b0, "R3");
      mode_sel = 2'b11; pad_in = 1'b0;
      repeat (4) tick();
      check(pad_oe, 1'b1, "R3");
      check(pad_out, 1'b1, "R3");
      check(stat_bit, 1'b0, "R3");

      // R4 with R6: rising edge latency
      mode_sel = 2'b01; trig_sel = 2'b01; pad_in = 1'b0;
      repeat (4) tick();
      check(stat_bit, 1'b0, "R6");
      pad_in = 1'b1;
      tick(); check(stat_bit, 1'b0, "R4");
      tick(); check(stat_bit, 1'b0, "R4");
      tick(); check(stat_bit, 1'b1, "R4");
      check(irq_line, 1'b0, "R11");
      stat_rd = 1'b1; tick(); stat_rd = 1'b0;
      check(stat_bit, 1'b0, "R9");
      repeat (3) tick();
      check(stat_bit, 1'b0, "R6");

      // R7: falling edge
      trig_sel = 2'b10; pad_in = 1'b0;
      repeat (3) tick();
      check(stat_bit, 1'b1, "R7");

      // R8 with R10: read in a cycle that also triggers
      trig_sel = 2'b11; pad_in = 1'b1;
      repeat (4) tick();
      stat_rd = 1'b1; tick(); stat_rd = 1'b0;
      check(stat_bit, 1'b1, "R10");
      pad_in = 1'b0;
      repeat (4) tick();
      stat_rd = 1'b1; tick(); stat_rd = 1'b0;
      check(stat_bit, 1'b0, "R9");

      // R5: level low, then leave input mode
      trig_sel = 2'b00;
      tick();
      check(stat_bit, 1'b1, "R5");
      mode_sel = 2'b10;
      tick();
      check(stat_bit, 1'b0, "R12");
      check(irq_line, 1'b1, "R11");

      // Random traffic judged against the reference every cycle
      for (int n = 0; n < 4000; n++) begin
         string tag;
         case (trig_sel)
            2'b00:   tag = "R5";
            2'b01:   tag = "R6";
            2'b10:   tag = "R7";
            default: tag = "R8";
         endcase
         if (mode_sel != 2'b01) tag = "R12";
         check(stat_bit, m_stat, tag);
         check(irq_line, !m_stat, "R11");
         check(pad_oe, mode_sel[1], "R3");
         check(pad_out, mode_sel == 2'b11, "R3");
         if ($urandom_range(0, 39) == 0) mode_sel = ($urandom_range(0, 3) == 0) ?
                                                   2'($urandom_range(0, 3)) : 2'b01;
         if ($urandom_range(0, 39) == 0) trig_sel = 2'($urandom_range(0, 3));
         if ($urandom_range(0, 3) == 0)  pad_in = ~pad_in;
         stat_rd = ($urandom_range(0, 7) == 0);
         tick();
      end
      summary();
   end
endmodule